// File: doc/BRIEF.md
# Dual-register self-test sequencer

This controller runs a two-phase built-in self-test over two combinational networks wired in a loop between two multi-mode test registers, called A and B. Network one reads A and feeds B; network two reads B and feeds A. In each phase, one register runs as a pseudorandom pattern source. The other register folds the network responses into a signature. The controller then shifts that signature out serially and compares it with a constant given at build time. After that it swaps the two roles and repeats.

The controller never touches the data paths. It drives a 2-bit mode code to each register, a serial scan bit into each chain, and a flag that tells the source register to isolate its parallel inputs. It reads back each chain's serial output. The results are a flag per phase, plus a pass and a done output.

The states are as follows:
- IDLE: waits for start.
- LOAD1: shifts the A seed into A and clears B.
- RUN1: A generates and B compresses the output of network one.
- UNLOAD1: shifts out B's signature and, in the same shifts, loads the B seed into B while A is cleared.
- RUN2: B generates and A compresses the output of network two.
- UNLOAD2: shifts out A's signature.
- DONE: holds the verdict.

The transitions are:
- IDLE to LOAD1 on start.
- LOAD1 to RUN1, UNLOAD1 to RUN2 and UNLOAD2 to DONE, each after SIG_W cycles.
- RUN1 to UNLOAD1 and RUN2 to UNLOAD2, each after RUN_CYCLES cycles.
- DONE to LOAD1 on start.

Top module: `bist_seq_ctrl`

## Requirements
- R1: After reset the state is IDLE. In IDLE both mode outputs are normal (2'b11), and done, pass, phase_fail, a_gen and b_gen are all 0.
- R2: A start seen in IDLE enters LOAD1 for SIG_W cycles. In LOAD1, a_mode is shift (2'b00) and b_mode is clear (2'b01). a_scan_in presents SEED_A most significant bit first, one bit per cycle.
- R3: RUN1 lasts RUN_CYCLES cycles, with both modes set to signature (2'b10), a_gen at 1 and b_gen at 0.
- R4: UNLOAD1 lasts SIG_W cycles, with b_mode shift and a_mode clear. b_scan_in presents SEED_B most significant bit first. b_scan_out is taken in most significant bit first. phase_fail[0] is set when the assembled word differs from EXP_SIG_B, and it can be seen from the first RUN2 cycle.
- R5: RUN2 lasts RUN_CYCLES cycles, with both modes set to signature, b_gen at 1 and a_gen at 0.
- R6: UNLOAD2 lasts SIG_W cycles, with a_mode shift and b_mode normal. a_scan_out is taken in most significant bit first. phase_fail[1] is set when the word differs from EXP_SIG_A.
- R7: done rises exactly 3*SIG_W + 2*RUN_CYCLES clock edges after the edge that accepts start. It then stays high until the next start. pass is 1 only while done is high and both phase_fail bits are 0.
- R8: start is ignored in every state other than IDLE and DONE. A pulse during a run does not change when done rises.
- R9: A start seen in DONE begins a new run and clears both phase_fail bits from the first LOAD1 cycle.
- R10: A fault that affects only network one sets only phase_fail[0]. A fault that affects only network two sets only phase_fail[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a test run when in IDLE or DONE |
| a_mode | output | 2 | Mode code for register A: 11 normal, 00 shift, 10 signature, 01 clear |
| b_mode | output | 2 | Mode code for register B, same encoding |
| a_gen | output | 1 | Register A is the pattern source; its parallel inputs are to be isolated |
| b_gen | output | 1 | Register B is the pattern source; its parallel inputs are to be isolated |
| a_scan_in | output | 1 | Serial data into register A's chain |
| a_scan_out | input | 1 | Serial data out of register A's chain (its top bit) |
| b_scan_in | output | 1 | Serial data into register B's chain |
| b_scan_out | input | 1 | Serial data out of register B's chain (its top bit) |
| done | output | 1 | The run is complete |
| pass | output | 1 | Both signatures matched (valid while done) |
| phase_fail | output | 2 | Bit 0: mismatch in the first phase; bit 1: mismatch in the second phase |

## Verification
The hardest situation to reach from the ports is a mismatch that falls on exactly one phase. Reaching it needs a real signature built from real data, so the bench has behavioural models of both registers and both networks, and it computes the golden signatures with constant functions before elaboration. A table then injects a stuck bit into one network, into the other, into both, or into neither. This separates the two phase flags and shows that the seed for the second phase, loaded during the first unload, does not leak across. A start pulse in the middle of a run, and a rerun from DONE after a failing run, cover the ignore and clear rules.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD1,
        ST_RUN1,
        ST_UNLOAD1,
        ST_RUN2,
        ST_UNLOAD2,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_CLEAR  = 2'b01,
        MODE_SIG    = 2'b10,
        MODE_NORMAL = 2'b11
    } reg_mode_t;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/scan_port.sv
module scan_port #(
    parameter int          W    = 8,
    parameter int          CW   = 5,
    parameter logic [W-1:0] SEED = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [CW-1:0] count,
    input  logic          ser_ret,
    output logic          ser_drive,
    output logic [W-1:0]  word_next
);

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  word_q;
    logic [IW-1:0] bit_idx;

    // seed leaves most significant bit first
    always_comb begin
        bit_idx   = IW'(W - 1) - IW'(count);
        ser_drive = SEED[bit_idx];
        word_next = {word_q[W-2:0], ser_ret};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= word_next;
        end
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import bist_seq_pkg::*;
#(
    parameter int SIG_W      = 8,
    parameter int RUN_CYCLES = 20,
    parameter int CW         = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    output seq_state_t    state_q,
    output seq_state_t    state_d,
    output logic          seg_last,
    output logic [1:0]    a_mode,
    output logic [1:0]    b_mode,
    output logic          a_gen,
    output logic          b_gen
);

    localparam logic [CW-1:0] SHIFT_LAST = CW'(SIG_W - 1);
    localparam logic [CW-1:0] RUN_LAST   = CW'(RUN_CYCLES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        seg_last = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_LOAD1;
            end
            ST_LOAD1: begin
                seg_last = (count == SHIFT_LAST);
                if (seg_last) state_d = ST_RUN1;
            end
            ST_RUN1: begin
                seg_last = (count == RUN_LAST);
                if (seg_last) state_d = ST_UNLOAD1;
            end
            ST_UNLOAD1: begin
                seg_last = (count == SHIFT_LAST);
                if (seg_last) state_d = ST_RUN2;
            end
            ST_RUN2: begin
                seg_last = (count == RUN_LAST);
                if (seg_last) state_d = ST_UNLOAD2;
            end
            ST_UNLOAD2: begin
                seg_last = (count == SHIFT_LAST);
                if (seg_last) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (start) state_d = ST_LOAD1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        a_mode = MODE_NORMAL;
        b_mode = MODE_NORMAL;
        a_gen  = 1'b0;
        b_gen  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                a_mode = MODE_NORMAL;
                b_mode = MODE_NORMAL;
            end
            ST_LOAD1: begin
                a_mode = MODE_SHIFT;
                b_mode = MODE_CLEAR;
            end
            ST_RUN1: begin
                a_mode = MODE_SIG;
                b_mode = MODE_SIG;
                a_gen  = 1'b1;
            end
            ST_UNLOAD1: begin
                a_mode = MODE_CLEAR;
                b_mode = MODE_SHIFT;
            end
            ST_RUN2: begin
                a_mode = MODE_SIG;
                b_mode = MODE_SIG;
                b_gen  = 1'b1;
            end
            ST_UNLOAD2: begin
                a_mode = MODE_SHIFT;
                b_mode = MODE_NORMAL;
            end
            default: begin
                a_mode = MODE_NORMAL;
                b_mode = MODE_NORMAL;
            end
        endcase
    end

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
    import bist_seq_pkg::*;
#(
    parameter int               SIG_W      = 8,
    parameter int               RUN_CYCLES = 20,
    parameter logic [SIG_W-1:0] SEED_A     = 8'hA5,
    parameter logic [SIG_W-1:0] SEED_B     = 8'h3C,
    parameter logic [SIG_W-1:0] EXP_SIG_B  = '0,
    parameter logic [SIG_W-1:0] EXP_SIG_A  = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic [1:0] a_mode,
    output logic [1:0] b_mode,
    output logic       a_gen,
    output logic       b_gen,
    output logic       a_scan_in,
    input  logic       a_scan_out,
    output logic       b_scan_in,
    input  logic       b_scan_out,
    output logic       done,
    output logic       pass,
    output logic [1:0] phase_fail
);

    localparam int SPAN = (RUN_CYCLES > SIG_W) ? RUN_CYCLES : SIG_W;
    localparam int CW   = $clog2(SPAN + 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             seg_last;
    logic [CW-1:0]    count;
    logic [SIG_W-1:0] word_a;
    logic [SIG_W-1:0] word_b;
    logic [1:0]       fail_q;
    logic             shift_a;
    logic             shift_b;
    logic             accept;

    seq_fsm #(
        .SIG_W     (SIG_W),
        .RUN_CYCLES(RUN_CYCLES),
        .CW        (CW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .count   (count),
        .state_q (state_q),
        .state_d (state_d),
        .seg_last(seg_last),
        .a_mode  (a_mode),
        .b_mode  (b_mode),
        .a_gen   (a_gen),
        .b_gen   (b_gen)
    );

    seq_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(state_d != state_q),
        .count  (count)
    );

    assign shift_a = (state_q == ST_LOAD1) || (state_q == ST_UNLOAD2);
    assign shift_b = (state_q == ST_UNLOAD1);
    assign accept  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    scan_port #(.W(SIG_W), .CW(CW), .SEED(SEED_A)) u_port_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_a),
        .count    (count),
        .ser_ret  (a_scan_out),
        .ser_drive(a_scan_in),
        .word_next(word_a)
    );

    scan_port #(.W(SIG_W), .CW(CW), .SEED(SEED_B)) u_port_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_b),
        .count    (count),
        .ser_ret  (b_scan_out),
        .ser_drive(b_scan_in),
        .word_next(word_b)
    );

    // verdict per phase, taken on the final shift of each unload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 2'b00;
        end else if (accept) begin
            fail_q <= 2'b00;
        end else if (seg_last && state_q == ST_UNLOAD1) begin
            fail_q[0] <= (word_b != EXP_SIG_B);
        end else if (seg_last && state_q == ST_UNLOAD2) begin
            fail_q[1] <= (word_a != EXP_SIG_A);
        end
    end

    assign done       = (state_q == ST_DONE);
    assign phase_fail = fail_q;
    assign pass       = done && (fail_q == 2'b00);

endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk
    import bist_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] a_mode,
    input logic [1:0] b_mode,
    input logic       a_gen,
    input logic       b_gen,
    input logic       done,
    input logic       pass,
    input logic [1:0] phase_fail,
    input seq_state_t state
);

    // R3
    gen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_gen, b_gen}));

    // R5
    gen_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_gen || b_gen) |-> (a_mode == 2'b10 && b_mode == 2'b10));

    // R4
    unload_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_mode == 2'b00) |-> (a_mode == 2'b01));

    // R7
    pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && phase_fail == 2'b00));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_RUN1) |=> (state != ST_LOAD1));

    // R9
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD1) |-> (phase_fail == 2'b00));

endmodule

bind bist_seq_ctrl bist_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .a_mode    (a_mode),
    .b_mode    (b_mode),
    .a_gen     (a_gen),
    .b_gen     (b_gen),
    .done      (done),
    .pass      (pass),
    .phase_fail(phase_fail),
    .state     (state_q)
);

// File: tb/tb_bist_seq_ctrl.sv
`timescale 1ns/1ps
module tb_bist_seq_ctrl;

    localparam int         W    = 8;
    localparam int         N    = 20;
    localparam logic [7:0] SDA  = 8'hA5;
    localparam logic [7:0] SDB  = 8'h3C;

    function automatic logic [7:0] net1(input logic [7:0] x);
        return (x & {x[6:0], x[7]}) ^ {x[4:0], x[7:5]};
    endfunction

    function automatic logic [7:0] net2(input logic [7:0] x);
        return (x | {x[1:0], x[7:2]}) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] fold(input logic [7:0] q, input logic [7:0] p);
        return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]} ^ p;
    endfunction

    function automatic logic [7:0] golden(input int ph);
        logic [7:0] g;
        logic [7:0] c;
        g = (ph == 0) ? SDA : SDB;
        c = 8'h00;
        for (int i = 0; i < N; i++) begin
            c = fold(c, (ph == 0) ? net1(g) : net2(g));
            g = fold(g, 8'h00);
        end
        return c;
    endfunction

    localparam logic [7:0] GOLD_B = golden(0);
    localparam logic [7:0] GOLD_A = golden(1);

    // {fault net1, fault net2, expected phase_fail[1:0]}
    localparam int NV = 4;
    localparam logic [3:0] VEC [NV] = '{4'b00_00, 4'b10_01, 4'b01_10, 4'b11_11};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] a_mode, b_mode, phase_fail;
    logic a_gen, b_gen, a_scan_in, b_scan_in, done, pass;
    logic [7:0] qa = 8'h00;
    logic [7:0] qb = 8'h00;
    logic flt1 = 1'b0;
    logic flt2 = 1'b0;
    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    bist_seq_ctrl #(
        .SIG_W(W), .RUN_CYCLES(N), .SEED_A(SDA), .SEED_B(SDB),
        .EXP_SIG_B(GOLD_B), .EXP_SIG_A(GOLD_A)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_mode(a_mode), .b_mode(b_mode), .a_gen(a_gen), .b_gen(b_gen),
        .a_scan_in(a_scan_in), .a_scan_out(qa[7]),
        .b_scan_in(b_scan_in), .b_scan_out(qb[7]),
        .done(done), .pass(pass), .phase_fail(phase_fail)
    );

    // behavioural test registers and networks with stuck-bit injection
    logic [7:0] n1o, n2o, pa, pb;
    always_comb begin
        n1o = net1(qa);
        if (flt1) n1o[0] = 1'b1;
        n2o = net2(qb);
        if (flt2) n2o[7] = 1'b0;
        pa = a_gen ? 8'h00 : n2o;
        pb = b_gen ? 8'h00 : n1o;
    end

    function automatic logic [7:0] reg_next(input logic [7:0] q, input logic [1:0] m,
                                            input logic si, input logic [7:0] p);
        case (m)
            2'b11:   return p;
            2'b00:   return {q[6:0], si};
            2'b10:   return fold(q, p);
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        qa <= reg_next(qa, a_mode, a_scan_in, pa);
        qb <= reg_next(qb, b_mode, b_scan_in, pb);
        cyc <= cyc + 1;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_seq(input logic [1:0] exp_fail, input logic poke);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (k == 0) chk(phase_fail == 2'b00, "R9 flags cleared", phase_fail, 0);
            chk(a_mode == 2'b00 && b_mode == 2'b01, "R2 load modes", {a_mode, b_mode}, 4'b0001);
            chk(a_scan_in == SDA[W-1-k], "R2 seed A bit", a_scan_in, SDA[W-1-k]);
            @(negedge clk);
        end
        for (int k = 0; k < N; k++) begin
            chk(a_mode == 2'b10 && b_mode == 2'b10 && a_gen && !b_gen, "R3 run1 modes",
                {a_mode, b_mode, a_gen, b_gen}, 6'b101010);
            start = poke && (k == 3);  // R8 pulse while busy
            @(negedge clk);
        end
        start = 1'b0;
        for (int k = 0; k < W; k++) begin
            chk(a_mode == 2'b01 && b_mode == 2'b00, "R4 unload1 modes", {a_mode, b_mode}, 4'b0100);
            chk(b_scan_in == SDB[W-1-k], "R4 seed B bit", b_scan_in, SDB[W-1-k]);
            @(negedge clk);
        end
        chk(phase_fail[0] == exp_fail[0], "R4 R10 phase 1 flag", phase_fail[0], exp_fail[0]);
        for (int k = 0; k < N; k++) begin
            chk(a_mode == 2'b10 && b_mode == 2'b10 && !a_gen && b_gen, "R5 run2 modes",
                {a_mode, b_mode, a_gen, b_gen}, 6'b101001);
            @(negedge clk);
        end
        for (int k = 0; k < W; k++) begin
            chk(a_mode == 2'b00 && b_mode == 2'b11 && !done, "R6 unload2 modes",
                {a_mode, b_mode, done}, 5'b00110);
            @(negedge clk);
        end
        chk(done == 1'b1, "R7 done timing", done, 1);
        chk(phase_fail == exp_fail, "R6 R10 phase flags", phase_fail, exp_fail);
        chk(pass == (exp_fail == 2'b00), "R7 pass", pass, exp_fail == 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(a_mode == 2'b11 && b_mode == 2'b11, "R1 reset modes", {a_mode, b_mode}, 4'b1111);
        chk(!done && !pass && phase_fail == 2'b00 && !a_gen && !b_gen, "R1 reset outputs",
            {done, pass, phase_fail, a_gen, b_gen}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(a_mode == 2'b11 && !done, "R1 idle after reset", {a_mode, done}, 3'b110);

        for (int v = 0; v < NV; v++) begin
            flt1 = VEC[v][3];
            flt2 = VEC[v][2];
            run_seq(VEC[v][1:0], 1'b0);
        end

        // R7: done holds in DONE without start
        repeat (5) @(negedge clk);
        chk(done && phase_fail == 2'b11, "R7 done holds", {done, phase_fail}, 3'b111);

        // R9: rerun from DONE after failing run; R8: start pulse during RUN1
        flt1 = 1'b0;
        flt2 = 1'b0;
        run_seq(2'b00, 1'b1);

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W + 4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(a_mode == 2'b11 && b_mode == 2'b11 && !done && !a_gen, "R1 mid-run reset",
            {a_mode, b_mode, done, a_gen}, 6'b111100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(a_mode == 2'b11 && !done, "R1 idle stays without start", {a_mode, done}, 3'b110);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule